// File: doc/BRIEF.md
# Rate-Half Constraint-Length-5 Convolutional Encoder

This block turns a serial stream of information bits into a stream of coded bit pairs. Each accepted input bit produces two coded bits. Two fixed generator polynomials make the pair: 23 and 33 in octal, which are 1 + D^3 + D^4 and 1 + D + D^3 + D^4. The encoder holds the four most recent information bits as a 4-bit state, which gives 16 trellis states. A matching trellis decoder downstream can start every frame in state 0 and can expect every frame to end in state 0.

A producer supplies bits through a valid/ready handshake. It marks the first bit of a frame with `frame_start` and the last bit with `frame_end`. After the last bit, the encoder adds four zero tail bits by itself. It holds `in_ready` low while it does so, and the tail drives the state back to zero. Coded pairs appear on `out_code` with `out_valid`, one cycle after the step that produced them.

Top module: `conv_enc_k5`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and the state is 0. The first bits after reset encode as if the previous four bits were zero.
- R2: For input bit b and state s[3:0], where s[3] is the most recent earlier bit, `out_code[1]` = b^s[1]^s[0] (generator 23 octal) and `out_code[0]` = b^s[3]^s[1]^s[0] (generator 33 octal).
- R3: Each encoding step loads the new bit into s[3] and shifts s[3:1] down into s[2:0].
- R4: `out_valid` is 1 in the cycle after an accepted bit or a tail step, and 0 in every other cycle.
- R5: A `frame_start` given while `in_ready` is 1 clears the state. A bit accepted together with it is encoded from state 0.
- R6: `frame_end` given with an accepted bit starts four tail steps, each with input bit 0. `in_ready` is 0 for exactly those four cycles, and each step yields one coded pair.
- R7: At the end of the tail the state is 0, so the next frame encodes from state 0 even without `frame_start`.
- R8: While `in_ready` is 0, `in_valid`, `in_bit`, `frame_start` and `frame_end` have no effect on the state or on the tail.
- R9: A cycle with `in_valid` low and no tail in progress leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Information bit is offered |
| in_bit | input | 1 | Information bit |
| frame_start | input | 1 | First bit of a frame; clears the state |
| frame_end | input | 1 | Last bit of a frame; starts the tail |
| in_ready | output | 1 | Encoder accepts a bit (0 during the tail) |
| out_valid | output | 1 | Coded pair is valid |
| out_code | output | 2 | Coded pair, generator 23 in bit 1, generator 33 in bit 0 |

## Verification
The assertions check the timing on every cycle. A coded pair must follow each accepted bit and each tail step, and no pair may appear without one. An accepted end-of-frame must drop `in_ready`, and the state must be zero whenever `in_ready` comes back. The bench scenarios show the rest by comparing coded values with an independent model of the two generators. This covers the generator arithmetic, the shift order of the state, the clearing by a frame start, and the four tail pairs. It also shows that inputs offered during the tail change neither the tail pairs nor the frame that follows.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  localparam int unsigned CE_K = 5;
  localparam logic [CE_K-1:0] CE_GEN_A = 5'o23;
  localparam logic [CE_K-1:0] CE_GEN_B = 5'o33;
endpackage

// File: rtl/conv_enc_step.sv
// One trellis step: coded pair and successor state for a given bit and state.
module conv_enc_step #(
  parameter int unsigned    K    = 5,
  parameter logic [K-1:0]   GEN_A = 5'o23,
  parameter logic [K-1:0]   GEN_B = 5'o33,
  localparam int unsigned   SW   = K - 1
) (
  input  logic          bit_i,
  input  logic [SW-1:0] cur_state,
  output logic [1:0]    pair,
  output logic [SW-1:0] next_state
);
  logic [K-1:0] window;

  always_comb begin
    // MSB of window is the current bit (D^0), LSB is the oldest bit (D^(K-1)).
    window     = {bit_i, cur_state};
    pair[1]    = ^(window & GEN_A);
    pair[0]    = ^(window & GEN_B);
    next_state = window[K-1:1];
  end
endmodule

// File: rtl/conv_enc_tail.sv
// Counts the zero tail steps that follow an end-of-frame handshake.
module conv_enc_tail #(
  parameter int unsigned  TAIL = 4,
  localparam int unsigned CW   = $clog2(TAIL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_tail,
  output logic tail_active
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_tail)
      cnt_d = CW'(TAIL);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tail_active = (cnt_q != '0);
endmodule

// File: rtl/conv_enc_k5.sv
module conv_enc_k5
  import conv_enc_pkg::*;
#(
  parameter int unsigned  K     = CE_K,
  parameter logic [K-1:0] GEN_A = CE_GEN_A,
  parameter logic [K-1:0] GEN_B = CE_GEN_B,
  localparam int unsigned SW    = K - 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       frame_start,
  input  logic       frame_end,
  output logic       in_ready,
  output logic       out_valid,
  output logic [1:0] out_code
);
  logic          tail_active;
  logic          accept, step, clr, enc_bit;
  logic [SW-1:0] state_q, state_d, base_state, succ;
  logic [1:0]    pair, code_d;

  conv_enc_tail #(.TAIL(SW)) u_tail (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_tail  (accept & frame_end),
    .tail_active (tail_active)
  );

  assign in_ready = ~tail_active;

  always_comb begin
    accept     = in_valid & in_ready;
    step       = accept | tail_active;
    clr        = frame_start & in_ready;
    enc_bit    = accept & in_bit;
    base_state = clr ? '0 : state_q;
  end

  conv_enc_step #(.K(K), .GEN_A(GEN_A), .GEN_B(GEN_B)) u_step (
    .bit_i      (enc_bit),
    .cur_state  (base_state),
    .pair       (pair),
    .next_state (succ)
  );

  always_comb begin
    state_d = base_state;
    code_d  = out_code;
    if (step) begin
      state_d = succ;
      code_d  = pair;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= '0;
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      state_q   <= state_d;
      out_valid <= step;
      out_code  <= code_d;
    end
  end
endmodule

// File: rtl/conv_enc_k5_chk.sv
module conv_enc_k5_chk #(
  parameter int unsigned SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          frame_end,
  input logic          out_valid,
  input logic [SW-1:0] state
);
  assert_pair_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_pair_during_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> out_valid);

  assert_no_spurious_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);

  assert_tail_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && frame_end) |=> !in_ready);

  assert_zero_after_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (state == '0));
endmodule

bind conv_enc_k5 conv_enc_k5_chk #(.SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .frame_end (frame_end),
  .out_valid (out_valid),
  .state     (state_q)
);

// File: tb/tb_conv_enc_k5.sv
`timescale 1ns/1ps
module tb_conv_enc_k5;
  logic clk, rst_n, in_valid, in_bit, frame_start, frame_end;
  logic in_ready, out_valid;
  logic [1:0] out_code;

  int total = 0;
  int bad   = 0;
  logic [3:0] m_st;   // bench model state, m_st[3] = most recent bit

  conv_enc_k5 dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .frame_start(frame_start), .frame_end(frame_end),
    .in_ready(in_ready), .out_valid(out_valid), .out_code(out_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [1:0] ref_pair(input logic b, input logic [3:0] s);
    logic g23, g33;
    g23 = b ^ s[1] ^ s[0];
    g33 = b ^ s[3] ^ s[1] ^ s[0];
    return {g23, g33};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer one bit at a negedge; check the pair at the following negedge.
  task automatic send(input logic b, input logic fs, input logic fe, input string req);
    logic [1:0] e;
    in_valid = 1'b1; in_bit = b; frame_start = fs; frame_end = fe;
    if (fs) m_st = 4'd0;
    e = ref_pair(b, m_st);
    m_st = {b, m_st[3:1]};
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b0; frame_end = 1'b0;
    chk(out_valid === 1'b1, {req, " valid"}, int'(out_valid), 1);
    chk(out_code === e, req, int'(out_code), int'(e));
  endtask

  // Four tail steps; optionally offer junk inputs while ready is low (R8).
  task automatic run_tail(input logic junk);
    logic [1:0] e;
    chk(in_ready === 1'b0, "R6 ready low", int'(in_ready), 0);
    for (int i = 0; i < 4; i++) begin
      if (junk) begin
        in_valid = 1'b1; in_bit = 1'b1; frame_start = 1'b1; frame_end = 1'b1;
      end
      e = ref_pair(1'b0, m_st);
      m_st = {1'b0, m_st[3:1]};
      @(posedge clk); @(negedge clk);
      chk(out_valid === 1'b1, "R6 tail valid", int'(out_valid), 1);
      chk(out_code === e, junk ? "R8 tail pair" : "R6 tail pair", int'(out_code), int'(e));
      chk(in_ready === (i == 3), "R6 ready span", int'(in_ready), int'(i == 3));
    end
    in_valid = 1'b0; frame_start = 1'b0; frame_end = 1'b0;
  endtask

  task automatic t_reset();
    chk(in_ready === 1'b1, "R1 ready", int'(in_ready), 1);
    chk(out_valid === 1'b0, "R1 valid", int'(out_valid), 0);
    m_st = 4'd0;
    send(1'b1, 1'b0, 1'b0, "R1 first pair");
    send(1'b0, 1'b0, 1'b0, "R3 second pair");
  endtask

  task automatic t_frame();
    logic [15:0] pat = 16'b1011_0010_1110_0101;
    for (int i = 0; i < 16; i++)
      send(pat[i], i == 0, i == 15, i == 0 ? "R5 start pair" : "R2 pair");
    run_tail(1'b0);
  endtask

  task automatic t_gaps();
    send(1'b1, 1'b0, 1'b0, "R7 pair after tail");
    @(posedge clk); @(negedge clk);
    chk(out_valid === 1'b0, "R4 idle no pair", int'(out_valid), 0);
    @(posedge clk); @(negedge clk);
    send(1'b1, 1'b0, 1'b0, "R9 pair after gap");
    send(1'b1, 1'b0, 1'b0, "R3 pair");
    send(1'b0, 1'b1, 1'b0, "R5 midframe start");
    send(1'b1, 1'b0, 1'b0, "R3 pair");
    send(1'b1, 1'b0, 1'b1, "R2 last pair");
    run_tail(1'b1);
  endtask

  task automatic t_after_junk();
    send(1'b0, 1'b0, 1'b0, "R8 state untouched");
    send(1'b1, 1'b0, 1'b0, "R8 state untouched");
    send(1'b1, 1'b0, 1'b0, "R2 pair");
    send(1'b1, 1'b0, 1'b0, "R2 pair");
    send(1'b1, 1'b0, 1'b1, "R2 all-ones pair");
    run_tail(1'b0);
    @(posedge clk); @(negedge clk);
    chk(out_valid === 1'b0, "R4 no pair after tail", int'(out_valid), 0);
  endtask

  initial begin
    in_valid = 1'b0; in_bit = 1'b0; frame_start = 1'b0; frame_end = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame();
    t_gaps();
    t_after_junk();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule